// File: doc/BRIEF.md
# I/O TLB Invalidation Sequencer

This block drives the command port of a 256-chain I/O translation cache and the valid-clear strobes of the I/O page table behind it. It does two jobs. The first is bring-up. On an init request it loads the chain-select mask, writes a zero data word, and then issues one direct-write command for every chain, so that the cache starts with no valid entries. The second is teardown of a mapping. On an unmap request it takes a start address and a byte count. It first clears the valid bit of every page-table entry the range covers, one page per cycle. After that it issues purge commands, and each purge steps through the range by one chain stride rather than by one page.

The chain stride is set at build time from the log2 of the physical memory size. The I/O virtual space is a quarter of memory, held between 1 MiB and 1 GiB. Its size in address bits minus 8 gives the bit position of the chain select. Commands leave one at a time over a valid/ready port. A single-cycle done pulse follows the last command of each operation.

Top module: `iotlb_inval_seq`

## Requirements
- R1: After reset, busy, cmd_valid, pte_clr and done are all low.
- R2: An init request emits exactly 258 commands, in this order:
  - cmd_kind 0 (mask load) with word 0xFF shifted left by the chain shift;
  - cmd_kind 1 (entry data) with word 0;
  - 256 commands of cmd_kind 2, each with word 35 OR (i shifted left by the chain shift), where i runs from 256 down to 1.
- R3: While cmd_valid is high and cmd_ready is low, cmd_valid, cmd_kind and cmd_word stay unchanged. A command is consumed only in a cycle where both are high.
- R4: An unmap request produces one pte_clr strobe per page of the rounded-up count, that is ceil(bytes/4096) strobes. They appear on consecutive cycles. pte_clr_idx starts at unmap_addr shifted right by 12 and rises by one on each strobe.
- R5: No command is offered until the last pte_clr strobe of the unmap has been issued.
- R6: An unmap issues ceil(rounded_bytes / chain_size) purges of cmd_kind 2. Purge k has word 33 OR (page-aligned unmap_addr + k times chain_size), with k counting from 0.
- R7: An unmap with a byte count of zero produces no pte_clr strobe and no command, and still ends with done.
- R8: done is high for exactly one cycle. That cycle directly follows the cycle in which the last command of the operation was accepted. busy is low from the next cycle.
- R9: Requests arriving while busy is high are ignored. When init and unmap requests arrive in the same idle cycle, the init runs and the unmap is dropped.
- R10: The chain shift equals clamp(MEM_LOG2 − 2, 20, 30) − 8. With the default MEM_LOG2 of 26 this is 16, a chain size of 64 KiB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Start the invalidate-all sequence (sampled when idle) |
| unmap_req | input | 1 | Start an unmap of the given range (sampled when idle) |
| unmap_addr | input | AW | Start I/O virtual address of the range |
| unmap_bytes | input | CNT_W | Length of the range in bytes |
| busy | output | 1 | An operation is in progress |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | The command consumer accepts the offered command |
| cmd_kind | output | 2 | 0 mask load, 1 entry data, 2 command word |
| cmd_word | output | AW | Command payload |
| pte_clr | output | 1 | Clear the valid bit of one page-table entry |
| pte_clr_idx | output | AW-12 | Page index of the entry to clear |
| done | output | 1 | One-cycle pulse at the end of an operation |

## Verification
The embedded assertions check these properties on every cycle:
- a stalled command holds steady;
- no command overlaps a clear strobe;
- clear strobes advance by exactly one page;
- the block stays silent while idle;
- done is a lone pulse that returns the block to idle.

The directed scenarios check what only a whole operation shows:
- the full 258-command init listing with its descending chain indices;
- the number of clears and purges for rounded byte counts, including a count one byte past a chain boundary, zero and the largest count;
- the purge addresses stepping by the 64 KiB stride;
- dropped requests, and init taking priority over unmap.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;

    typedef enum logic [1:0] {
        K_MASK  = 2'd0,
        K_DATA  = 2'd1,
        K_CMD   = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INIT,
        ST_CLEAR,
        ST_PURGE
    } seq_state_e;

    localparam int TLB_CHAINS    = 256;
    localparam int CHAIN_BITS    = 8;
    localparam int CODE_TLB_WR   = 35;
    localparam int CODE_PURGE    = 33;
    localparam int IOV_MIN_LOG2  = 20;
    localparam int IOV_MAX_LOG2  = 30;

    // I/O virtual space: a quarter of memory, clamped to [1 MiB, 1 GiB]
    function automatic int iov_log2(input int mem_log2);
        int v;
        v = mem_log2 - 2;
        if (v < IOV_MIN_LOG2) v = IOV_MIN_LOG2;
        if (v > IOV_MAX_LOG2) v = IOV_MAX_LOG2;
        return v;
    endfunction

endpackage

// File: rtl/iotlb_stepper.sv
module iotlb_stepper #(
    parameter int AW   = 32,
    parameter int CW   = 9,
    parameter int STEP = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    input  logic          adv,
    output logic          active,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [CW-1:0] remain_q;

    assign last = active && (remain_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            addr     <= '0;
            remain_q <= '0;
        end else if (start) begin
            active   <= (count != '0);
            addr     <= base;
            remain_q <= count;
        end else if (active && adv) begin
            addr     <= addr + AW'(STEP);
            remain_q <= remain_q - CW'(1);
            if (remain_q == CW'(1)) active <= 1'b0;
        end
    end

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (active && adv && !last && !start) |=> (active && addr == $past(addr) + AW'(STEP))) // R4
        else $error("stepper advance broken");

endmodule

// File: rtl/iotlb_init_gen.sv
module iotlb_init_gen
    import iotlb_pkg::*;
#(
    parameter int AW = 32,
    parameter int CS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          adv,
    output logic          active,
    output cmd_kind_e     kind,
    output logic [AW-1:0] word
);
    localparam int TOTAL = TLB_CHAINS + 2;
    localparam int SW    = $clog2(TOTAL + 1);

    logic [SW-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            step_q <= '0;
        end else if (start) begin
            active <= 1'b1;
            step_q <= '0;
        end else if (active && adv) begin
            if (step_q == SW'(TOTAL - 1)) active <= 1'b0;
            else                          step_q <= step_q + SW'(1);
        end
    end

    always_comb begin
        if (step_q == SW'(0)) begin
            kind = K_MASK;
            word = AW'({CHAIN_BITS{1'b1}}) << CS;
        end else if (step_q == SW'(1)) begin
            kind = K_DATA;
            word = '0;
        end else begin
            kind = K_CMD;
            word = AW'(CODE_TLB_WR) | (AW'(TOTAL - int'(step_q)) << CS);
        end
    end

    AST_INIT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (active && !adv && !start) |=> (active && $stable(step_q))) // R3
        else $error("init generator moved while stalled");

endmodule

// File: rtl/iotlb_inval_seq.sv
module iotlb_inval_seq
    import iotlb_pkg::*;
#(
    parameter int AW       = 32,
    parameter int CNT_W    = 20,
    parameter int PS       = 12,
    parameter int MEM_LOG2 = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init_req,
    input  logic             unmap_req,
    input  logic [AW-1:0]    unmap_addr,
    input  logic [CNT_W-1:0] unmap_bytes,
    output logic             busy,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [1:0]       cmd_kind,
    output logic [AW-1:0]    cmd_word,
    output logic             pte_clr,
    output logic [AW-PS-1:0] pte_clr_idx,
    output logic             done
);
    localparam int IOV_LOG2 = iov_log2(MEM_LOG2);
    localparam int CS       = IOV_LOG2 - CHAIN_BITS;   // chain-ID shift
    localparam int CPS      = CS - PS;                 // pages per chain, log2
    localparam int PCW      = CNT_W + 1 - PS;          // page-count width
    localparam int PAGE     = 1 << PS;
    localparam int PPC      = 1 << CPS;

    seq_state_e st_q;

    logic [CNT_W:0]  bytes_up;
    logic [PCW-1:0]  n_pages;
    logic [PCW:0]    pages_up;
    logic [PCW-1:0]  n_purges;
    logic [AW-1:0]   page_base;
    logic            unused_offset;

    logic [AW-1:0]   pur_base_q;
    logic [PCW-1:0]  pur_cnt_q;

    logic            ini_start, clr_start, pur_start;
    logic            ini_active, clr_active, clr_last, pur_active, pur_last;
    cmd_kind_e       ini_kind;
    logic [AW-1:0]   ini_word, pur_addr;
    logic [AW-PS-1:0] clr_addr;

    // range arithmetic: round bytes up to pages, pages up to chains
    assign bytes_up      = {1'b0, unmap_bytes} + (CNT_W+1)'(PAGE - 1);
    assign n_pages       = bytes_up[CNT_W:PS];
    assign pages_up      = {1'b0, n_pages} + (PCW+1)'(PPC - 1);
    assign n_purges      = PCW'(pages_up >> CPS);
    assign page_base     = {unmap_addr[AW-1:PS], {PS{1'b0}}};
    assign unused_offset = ^unmap_addr[PS-1:0];

    assign ini_start = (st_q == ST_IDLE) && init_req;
    assign clr_start = (st_q == ST_IDLE) && !init_req && unmap_req;
    assign pur_start = (st_q == ST_CLEAR) && (!clr_active || clr_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            pur_base_q <= '0;
            pur_cnt_q  <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (init_req) st_q <= ST_INIT;
                    else if (unmap_req) begin
                        st_q       <= ST_CLEAR;
                        pur_base_q <= page_base;
                        pur_cnt_q  <= n_purges;
                    end
                end
                ST_INIT:  if (!ini_active) st_q <= ST_IDLE;
                ST_CLEAR: if (pur_start)   st_q <= ST_PURGE;
                ST_PURGE: if (!pur_active) st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    iotlb_init_gen #(.AW(AW), .CS(CS)) u_init (
        .clk    (clk),
        .rst    (rst),
        .start  (ini_start),
        .adv    (cmd_ready),
        .active (ini_active),
        .kind   (ini_kind),
        .word   (ini_word)
    );

    iotlb_stepper #(.AW(AW - PS), .CW(PCW), .STEP(1)) u_clr (
        .clk    (clk),
        .rst    (rst),
        .start  (clr_start),
        .base   (unmap_addr[AW-1:PS]),
        .count  (n_pages),
        .adv    (st_q == ST_CLEAR),
        .active (clr_active),
        .addr   (clr_addr),
        .last   (clr_last)
    );

    iotlb_stepper #(.AW(AW), .CW(PCW), .STEP(1 << CS)) u_pur (
        .clk    (clk),
        .rst    (rst),
        .start  (pur_start),
        .base   (pur_base_q),
        .count  (pur_cnt_q),
        .adv    (cmd_ready && (st_q == ST_PURGE)),
        .active (pur_active),
        .addr   (pur_addr),
        .last   (pur_last)
    );

    always_comb begin
        busy        = (st_q != ST_IDLE);
        pte_clr     = (st_q == ST_CLEAR) && clr_active;
        pte_clr_idx = clr_addr;
        cmd_valid   = 1'b0;
        cmd_kind    = K_CMD;
        cmd_word    = '0;
        done        = 1'b0;
        if (st_q == ST_INIT) begin
            cmd_valid = ini_active;
            cmd_kind  = ini_kind;
            cmd_word  = ini_word;
            done      = !ini_active;
        end else if (st_q == ST_PURGE) begin
            cmd_valid = pur_active;
            cmd_word  = pur_addr | AW'(CODE_PURGE);
            done      = !pur_active;
        end
    end

    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word) && $stable(cmd_kind))) // R3
        else $error("stalled command changed");

    AST_CLEAR_FIRST: assert property (@(posedge clk) disable iff (rst)
        pte_clr |-> !cmd_valid) // R5
        else $error("command overlaps a page clear");

    AST_CLR_CONSEC: assert property (@(posedge clk) disable iff (rst)
        (pte_clr && $past(pte_clr)) |-> (pte_clr_idx == $past(pte_clr_idx) + 1'b1)) // R4
        else $error("clear index skipped");

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!cmd_valid && !pte_clr && !done)) // R1
        else $error("output active while idle");

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy)) // R8
        else $error("done not a lone pulse");

    AST_PURGE_LAST: assert property (@(posedge clk) disable iff (rst)
        (pur_last && cmd_ready) |=> done) // R8
        else $error("done missing after last purge");

endmodule

// File: tb/tb_iotlb_inval_seq.sv
module tb_iotlb_inval_seq;
    localparam int AW = 32;
    localparam int CW = 20;
    localparam int PS = 12;
    localparam int CHAIN = 65536;  // R10: clamp(26-2,20,30)-8 = 16

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init_req = 1'b0, unmap_req = 1'b0;
    logic [AW-1:0] unmap_addr = '0;
    logic [CW-1:0] unmap_bytes = '0;
    logic busy, cmd_valid, cmd_ready, pte_clr, done;
    logic [1:0] cmd_kind;
    logic [AW-1:0] cmd_word;
    logic [AW-PS-1:0] pte_clr_idx;

    always #10 clk = ~clk;

    iotlb_inval_seq dut (
        .clk(clk), .rst(rst), .init_req(init_req), .unmap_req(unmap_req),
        .unmap_addr(unmap_addr), .unmap_bytes(unmap_bytes), .busy(busy),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_word(cmd_word), .pte_clr(pte_clr), .pte_clr_idx(pte_clr_idx),
        .done(done)
    );

    int n_chk = 0, n_err = 0, cyc = 0;
    logic stall = 1'b0;
    logic wd_hit = 1'b0;

    // monitor storage
    logic [AW-1:0]    mw [0:299];
    logic [1:0]       mk [0:299];
    logic [AW-PS-1:0] mi [0:299];
    int cn, qn, done_n, done_cyc, last_cmd_cyc, first_cmd_cyc, last_clr_cyc;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #2;
        cmd_ready = stall ? ((cyc % 3) != 0) : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (pte_clr) begin
                if (qn < 300) mi[qn] = pte_clr_idx;
                qn++;
                last_clr_cyc = cyc;
            end
            if (cmd_valid && cmd_ready) begin
                if (cn < 300) begin mw[cn] = cmd_word; mk[cn] = cmd_kind; end
                if (cn == 0) first_cmd_cyc = cyc;
                cn++;
                last_cmd_cyc = cyc;
            end
            if (done) begin done_n++; done_cyc = cyc; end
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !wd_hit) begin
            wd_hit = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog: run hung, act=%0d exp<=150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: act=0x%0h exp=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic mon_clear();
        cn = 0; qn = 0; done_n = 0; done_cyc = -1;
        last_cmd_cyc = -1; first_cmd_cyc = -1; last_clr_cyc = -1;
    endtask

    task automatic pulse(input bit ini, input bit unm, input logic [AW-1:0] a,
                         input logic [CW-1:0] b);
        @(posedge clk); #1;
        init_req = ini; unmap_req = unm; unmap_addr = a; unmap_bytes = b;
        @(posedge clk); #1;
        init_req = 1'b0; unmap_req = 1'b0;
        unmap_addr = 32'hDEAD_BEEF; unmap_bytes = '1;
    endtask

    task automatic wait_end(input string req);
        int k = 0;
        while (done_n == 0 && k < 20000) begin @(posedge clk); k++; end
        repeat (3) @(posedge clk);
        #5;
        chk(done_n == 1, req, "done pulse cycles", done_n, 1);
        chk(busy == 1'b0, req, "busy after done", busy, 0);
    endtask

    task automatic check_init_stream(input string req);
        int bad = 0;
        chk(cn == 258, req, "init command count", cn, 258);
        chk(mk[0] == 2'd0 && mw[0] == 32'h00FF_0000, req, "mask load word", mw[0], 32'h00FF_0000);
        chk(mk[1] == 2'd1 && mw[1] == 32'h0, req, "entry data word", mw[1], 0);
        for (int k = 2; k < 258 && k < cn; k++) begin
            logic [AW-1:0] e;
            e = 32'd35 | (32'(258 - k) << 16);
            if ((mk[k] != 2'd2 || mw[k] != e) && bad == 0) begin
                chk(1'b0, req, $sformatf("init word %0d", k), mw[k], e);
                bad++;
            end
        end
        chk(bad == 0, req, "init descending chain words", bad, 0);
        chk(mw[2] == 32'h0100_0023 && mw[257] == 32'h0001_0023, req,
            "first and last chain write", mw[257], 32'h0001_0023);
    endtask

    // R1
    task automatic t_reset();
        #5;
        chk(busy == 0 && cmd_valid == 0 && pte_clr == 0 && done == 0, "R1",
            "outputs after reset", {busy, cmd_valid, pte_clr, done}, 0);
    endtask

    // R2 R3 R8
    task automatic t_init(input bit st);
        stall = st;
        mon_clear();
        pulse(1'b1, 1'b0, '0, '0);
        wait_end("R8");
        check_init_stream(st ? "R3" : "R2");
        chk(done_cyc == last_cmd_cyc + 1, "R8", "done follows last command", done_cyc, last_cmd_cyc + 1);
        stall = 1'b0;
    endtask

    // R4 R5 R6 R7 R10
    task automatic t_unmap(input logic [AW-1:0] a, input int bytes, input bit st, input string tag);
        int pages, purges, bad;
        pages  = (bytes + 4095) / 4096;
        purges = (pages * 4096 + CHAIN - 1) / CHAIN;
        stall = st;
        mon_clear();
        pulse(1'b0, 1'b1, a, CW'(bytes));
        wait_end("R8");
        chk(qn == pages, "R4", {tag, " clear count"}, qn, pages);
        bad = 0;
        for (int k = 0; k < qn && k < 300; k++)
            if (mi[k] != (a >> 12) + k) bad++;
        chk(bad == 0, "R4", {tag, " clear indices"}, bad, 0);
        chk(cn == purges, "R6", {tag, " purge count"}, cn, purges);
        bad = 0;
        for (int k = 0; k < cn && k < 300; k++)
            if (mk[k] != 2'd2 || mw[k] != (((a & 32'hFFFF_F000) + 32'(k * CHAIN)) | 32'd33)) bad++;
        chk(bad == 0, "R10", {tag, " purge words on 64 KiB stride"}, bad, 0);
        if (qn > 0 && cn > 0)
            chk(last_clr_cyc < first_cmd_cyc, "R5", {tag, " clears precede purges"},
                last_clr_cyc, first_cmd_cyc);
        if (cn > 0)
            chk(done_cyc == last_cmd_cyc + 1, "R8", {tag, " done timing"}, done_cyc, last_cmd_cyc + 1);
        stall = 1'b0;
    endtask

    // R7
    task automatic t_zero();
        mon_clear();
        pulse(1'b0, 1'b1, 32'h0050_0000, '0);
        wait_end("R7");
        chk(qn == 0 && cn == 0, "R7", "zero-length activity", qn + cn, 0);
    endtask

    // R9
    task automatic t_busy_ignore();
        mon_clear();
        pulse(1'b0, 1'b1, 32'h0040_0000, CW'(32'h20000));
        repeat (4) @(posedge clk);
        #1; init_req = 1'b1; unmap_req = 1'b1;
        @(posedge clk); #1; init_req = 1'b0; unmap_req = 1'b0;
        wait_end("R9");
        chk(cn == 2 && qn == 32, "R9", "requests while busy dropped", cn * 1000 + qn, 2032);
        chk(mk[0] == 2'd2 && mw[0] == 32'h0040_0021, "R9", "first command is purge", mw[0], 32'h0040_0021);
        repeat (5) @(posedge clk);
        #5;
        chk(busy == 0, "R9", "no deferred operation", busy, 0);
    endtask

    task automatic t_priority();
        mon_clear();
        pulse(1'b1, 1'b1, 32'h0040_0000, CW'(32'h3000));
        wait_end("R9");
        chk(qn == 0, "R9", "unmap dropped when init wins", qn, 0);
        check_init_stream("R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_init(1'b0);
        t_init(1'b1);
        t_unmap(32'h0012_3456, 32'h1001,  1'b0, "two pages");
        t_unmap(32'h0040_0000, 32'h20000, 1'b0, "two chains");
        t_unmap(32'h00AB_F000, 32'h10001, 1'b1, "chain plus one byte stalled");
        t_unmap(32'h0800_0000, 32'hFFFFF, 1'b0, "largest count");
        t_zero();
        t_busy_ignore();
        t_priority();
        summary();
        $finish;
    end
endmodule